// File: doc/BRIEF.md
# Trace Byte Stream Aligner and Header Classifier

This block sits behind a trace frame deformatter and sees the byte stream of one trace source only. Such a stream has no built-in byte alignment: a downstream packet decoder cannot tell a header from a payload byte until it has seen the alignment marker. That marker is a run of at least five zero bytes closed by a byte of value 0x80. The block hunts for the marker and reports every byte as unsynchronized until it finds it. Once locked, it tags every byte as either a packet header or a payload byte, and gives each header a coarse type code.

Bytes enter one per cycle on a valid/ready handshake gated by a clock enable. Each accepted byte produces exactly one registered strobe in the following cycle: unsynchronized, header (with a type), or payload. Packet lengths are tracked just far enough to find the next header. Instruction-sync packets are six bytes long. Branch packets continue while bit 7 is set, up to five bytes. In-stream alignment markers are followed to their closing 0x80. A malformed marker, a flush or a reset drops the lock.

Top module: `trc_stream_sync`

## Requirements
- R1: After reset, `locked`, `unsync_stb`, `hdr_stb` and `pay_stb` are low and `hdr_type` is 0.
- R2: While not locked, every accepted byte raises `unsync_stb` in the next cycle and never `hdr_stb` or `pay_stb`, whatever its value.
- R3: Lock is gained when a byte 0x80 is accepted after at least five consecutive accepted 0x00 bytes; that 0x80 is reported with `hdr_stb` and type 1 (alignment), and `locked` rises in the same cycle. A 0x80 after fewer than five zeros is reported unsynchronized and does not lock.
- R4: Every accepted byte (`in_valid` and `in_ready` both high) gives exactly one of the three strobes in the next cycle; a cycle with no accepted byte gives none. `hdr_type` is 0 whenever `hdr_stb` is low.
- R5: A header byte 0x08 is reported with type 2 (instruction sync); the next five accepted bytes are payload, and the byte after them is a header.
- R6: A header byte with bit 0 set and not 0x00/0x08 is reported with type 3 (branch). While the latest byte of the packet has bit 7 set, the next byte is payload, up to a total packet length of five bytes; the byte after the packet is a header.
- R7: A header byte with bit 7 set and bit 0 clear is reported with type 4 (atom) and is a one-byte packet.
- R8: A header byte 0x00 is reported with type 1 (alignment). Later 0x00 bytes are payload. A 0x80 is payload and ends the packet if at least four zeros followed the header. Any other byte, or an early 0x80, drops the lock and is reported unsynchronized.
- R9: A header byte matching none of the rules above (checked in the order 0x00, 0x08, bit 0, bit 7) is reported with type 5 (other) and is a one-byte packet.
- R10: A high `clr` in any cycle, with or without `ce`, returns the block to the unlocked state at the next edge and produces no strobe.
- R11: `in_ready` follows `ce`; while `ce` is low no byte is accepted and the lock state and packet position are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous flush back to unlocked state |
| ce | input | 1 | Clock enable; gates byte acceptance |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take a byte this cycle |
| in_data | input | 8 | Trace byte of one source |
| locked | output | 1 | Stream alignment found |
| unsync_stb | output | 1 | Last accepted byte arrived while unlocked |
| hdr_stb | output | 1 | Last accepted byte was a packet header |
| hdr_type | output | 3 | Header class: 1 alignment, 2 instruction sync, 3 branch, 4 atom, 5 other, 0 none |
| pay_stb | output | 1 | Last accepted byte was packet payload |

## Verification
A wrong packet position does not stay hidden. A miscounted instruction-sync or branch length turns a payload byte into a header strobe, or a header into payload, on the very next byte after the true packet end. Because the bench reference is compared on every clock, the failure shows at that byte. A zero counter that saturates or clears wrongly shows as lock gained one byte too early or never. A stale state after a flush shows as a header or payload strobe where an unsynchronized strobe was due, on the first byte after the flush.

// File: rtl/trc_sync_pkg.sv
package trc_sync_pkg;

  typedef enum logic [2:0] {
    HK_NONE   = 3'd0,
    HK_ALIGN  = 3'd1,
    HK_ISYNC  = 3'd2,
    HK_BRANCH = 3'd3,
    HK_ATOM   = 3'd4,
    HK_OTHER  = 3'd5
  } hdr_kind_e;

  typedef enum logic [2:0] {
    PS_HUNT   = 3'd0,
    PS_HEAD   = 3'd1,
    PS_ALIGN  = 3'd2,
    PS_ISYNC  = 3'd3,
    PS_BRANCH = 3'd4
  } pkt_state_e;

  localparam logic [7:0] BYTE_ZERO  = 8'h00;
  localparam logic [7:0] BYTE_CLOSE = 8'h80;
  localparam logic [7:0] BYTE_ISYNC = 8'h08;

endpackage

// File: rtl/trc_align_hunt.sv
module trc_align_hunt #(
  parameter int ZERO_RUN = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       acc,
  input  logic       arm,
  input  logic [7:0] byte_i,
  output logic       match_o
);
  import trc_sync_pkg::*;

  localparam int ZW = $clog2(ZERO_RUN + 1);
  localparam logic [ZW-1:0] ZMAX = ZW'(ZERO_RUN);

  logic [ZW-1:0] zrun_q;
  logic [ZW-1:0] zrun_d;

  always_comb begin
    zrun_d = zrun_q;
    if (!arm) begin
      zrun_d = '0;
    end else if (byte_i == BYTE_ZERO) begin
      if (zrun_q != ZMAX) zrun_d = zrun_q + ZW'(1);
    end else begin
      zrun_d = '0;
    end
  end

  assign match_o = arm && (byte_i == BYTE_CLOSE) && (zrun_q == ZMAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zrun_q <= '0;
    end else if (clr) begin
      zrun_q <= '0;
    end else if (acc) begin
      zrun_q <= zrun_d;
    end
  end

endmodule

// File: rtl/trc_hdr_decode.sv
module trc_hdr_decode (
  input  logic [7:0]                  byte_i,
  output trc_sync_pkg::hdr_kind_e     kind_o
);
  import trc_sync_pkg::*;

  always_comb begin
    if (byte_i == BYTE_ZERO)       kind_o = HK_ALIGN;
    else if (byte_i == BYTE_ISYNC) kind_o = HK_ISYNC;
    else if (byte_i[0])            kind_o = HK_BRANCH;
    else if (byte_i[7])            kind_o = HK_ATOM;
    else                           kind_o = HK_OTHER;
  end

endmodule

// File: rtl/trc_stream_sync.sv
module trc_stream_sync #(
  parameter int ZERO_RUN  = 5,
  parameter int ISYNC_LEN = 6,
  parameter int BR_MAX    = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       ce,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  output logic       locked,
  output logic       unsync_stb,
  output logic       hdr_stb,
  output logic [2:0] hdr_type,
  output logic       pay_stb
);
  import trc_sync_pkg::*;

  localparam int MAX_A = (ISYNC_LEN > BR_MAX) ? ISYNC_LEN : BR_MAX;
  localparam int MAX_L = (MAX_A > ZERO_RUN) ? MAX_A : ZERO_RUN;
  localparam int CW    = $clog2(MAX_L + 1);
  localparam logic [CW-1:0] ISYNC_REM = CW'(ISYNC_LEN - 1);
  localparam logic [CW-1:0] BR_REM    = CW'(BR_MAX - 1);
  localparam logic [CW-1:0] ZERO_REM  = CW'(ZERO_RUN - 1);
  localparam logic [CW-1:0] ONE       = CW'(1);

  pkt_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          acc;
  logic          hunt_match;
  hdr_kind_e     kind;

  logic          uns_d, hdr_d, pay_d;
  hdr_kind_e     typ_d;
  logic          uns_q, hdr_q, pay_q;
  hdr_kind_e     typ_q;

  assign in_ready = ce;
  assign acc      = ce && in_valid;

  trc_align_hunt #(.ZERO_RUN(ZERO_RUN)) u_hunt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .acc     (acc),
    .arm     (st_q == PS_HUNT),
    .byte_i  (in_data),
    .match_o (hunt_match)
  );

  trc_hdr_decode u_dec (
    .byte_i (in_data),
    .kind_o (kind)
  );

  // next-state and strobe logic
  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    uns_d = 1'b0;
    hdr_d = 1'b0;
    pay_d = 1'b0;
    typ_d = HK_NONE;
    if (acc && !clr) begin
      unique case (st_q)
        PS_HUNT: begin
          if (hunt_match) begin
            hdr_d = 1'b1;
            typ_d = HK_ALIGN;
            st_d  = PS_HEAD;
          end else begin
            uns_d = 1'b1;
          end
        end
        PS_HEAD: begin
          hdr_d = 1'b1;
          typ_d = kind;
          unique case (kind)
            HK_ALIGN: begin
              st_d  = PS_ALIGN;
              cnt_d = ZERO_REM;
            end
            HK_ISYNC: begin
              st_d  = PS_ISYNC;
              cnt_d = ISYNC_REM;
            end
            HK_BRANCH: begin
              if (in_data[7]) begin
                st_d  = PS_BRANCH;
                cnt_d = BR_REM;
              end
            end
            default: ;
          endcase
        end
        PS_ALIGN: begin
          if (in_data == BYTE_ZERO) begin
            pay_d = 1'b1;
            if (cnt_q != '0) cnt_d = cnt_q - ONE;
          end else if (in_data == BYTE_CLOSE && cnt_q == '0) begin
            pay_d = 1'b1;
            st_d  = PS_HEAD;
          end else begin
            uns_d = 1'b1;
            st_d  = PS_HUNT;
            cnt_d = '0;
          end
        end
        PS_ISYNC: begin
          pay_d = 1'b1;
          cnt_d = cnt_q - ONE;
          if (cnt_q == ONE) st_d = PS_HEAD;
        end
        PS_BRANCH: begin
          pay_d = 1'b1;
          cnt_d = cnt_q - ONE;
          if (!in_data[7] || cnt_q == ONE) st_d = PS_HEAD;
        end
        default: begin
          st_d  = PS_HUNT;
          cnt_d = '0;
        end
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PS_HUNT;
      cnt_q <= '0;
      uns_q <= 1'b0;
      hdr_q <= 1'b0;
      pay_q <= 1'b0;
      typ_q <= HK_NONE;
    end else begin
      uns_q <= uns_d;
      hdr_q <= hdr_d;
      pay_q <= pay_d;
      typ_q <= typ_d;
      if (clr) begin
        st_q  <= PS_HUNT;
        cnt_q <= '0;
      end else if (acc) begin
        st_q  <= st_d;
        cnt_q <= cnt_d;
      end
    end
  end

  assign locked     = (st_q != PS_HUNT);
  assign unsync_stb = uns_q;
  assign hdr_stb    = hdr_q;
  assign pay_stb    = pay_q;
  assign hdr_type   = typ_q;

endmodule

// File: rtl/trc_stream_sync_chk.sv
module trc_stream_sync_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clr,
  input logic       ce,
  input logic       in_valid,
  input logic       in_ready,
  input logic       locked,
  input logic       unsync_stb,
  input logic       hdr_stb,
  input logic [2:0] hdr_type,
  input logic       pay_stb
);

  p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({unsync_stb, hdr_stb, pay_stb}));

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!(in_valid && in_ready) || clr) |=> !(unsync_stb || hdr_stb || pay_stb));

  p_type_none_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_stb |-> (hdr_type == 3'd0));

  p_type_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_stb |-> (hdr_type >= 3'd1 && hdr_type <= 3'd5));

  p_unsync_unlocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    unsync_stb |-> !locked);

  p_classify_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_stb || pay_stb) |-> locked);

  p_lock_on_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> (hdr_stb && hdr_type == 3'd1));

  p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !locked);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce && !clr) |=> $stable(locked));

endmodule

bind trc_stream_sync trc_stream_sync_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clr        (clr),
  .ce         (ce),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .locked     (locked),
  .unsync_stb (unsync_stb),
  .hdr_stb    (hdr_stb),
  .hdr_type   (hdr_type),
  .pay_stb    (pay_stb)
);

// File: tb/tb_trc_stream_sync.sv
module tb_trc_stream_sync;

  localparam time CLK_PERIOD = 10ns;

  logic       clk;
  logic       rst_n;
  logic       clr;
  logic       ce;
  logic       in_valid;
  logic       in_ready;
  logic [7:0] in_data;
  logic       locked;
  logic       unsync_stb;
  logic       hdr_stb;
  logic [2:0] hdr_type;
  logic       pay_stb;

  int vectors;
  int miscompares;

  // reference model state: 0 hunt, 1 header, 2 align body, 3 isync body, 4 branch body
  int m_mode;
  int m_zeros;
  int m_left;

  trc_stream_sync dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .ce         (ce),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .locked     (locked),
    .unsync_stb (unsync_stb),
    .hdr_stb    (hdr_stb),
    .hdr_type   (hdr_type),
    .pay_stb    (pay_stb)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic compare(input string tag, input bit e_lk, input bit e_un,
                         input bit e_hd, input int e_ty, input bit e_py, input bit e_rdy);
    vectors++;
    if (locked !== e_lk || unsync_stb !== e_un || hdr_stb !== e_hd ||
        hdr_type !== 3'(e_ty) || pay_stb !== e_py || in_ready !== e_rdy) begin
      miscompares++;
      $display("FAIL %s: got lk=%0b un=%0b hd=%0b ty=%0d py=%0b rdy=%0b exp lk=%0b un=%0b hd=%0b ty=%0d py=%0b rdy=%0b",
               tag, locked, unsync_stb, hdr_stb, hdr_type, pay_stb, in_ready,
               e_lk, e_un, e_hd, e_ty, e_py, e_rdy);
    end
  endtask

  // one clock: drive at negedge, predict, compare at the following negedge
  task automatic step(input bit v, input logic [7:0] b, input bit c, input bit f, input string tag);
    bit e_un, e_hd, e_py;
    int e_ty;
    e_un = 0; e_hd = 0; e_py = 0; e_ty = 0;
    in_valid = v; in_data = b; ce = c; clr = f;
    if (f) begin
      m_mode = 0; m_zeros = 0; m_left = 0;
    end else if (v && c) begin
      if (m_mode == 0) begin
        if (b == 8'h80 && m_zeros >= 5) begin
          e_hd = 1; e_ty = 1; m_mode = 1; m_zeros = 0;
        end else begin
          e_un = 1;
          m_zeros = (b == 8'h00) ? ((m_zeros < 5) ? m_zeros + 1 : 5) : 0;
        end
      end else if (m_mode == 1) begin
        e_hd = 1;
        if (b == 8'h00) begin e_ty = 1; m_mode = 2; m_left = 4; end
        else if (b == 8'h08) begin e_ty = 2; m_mode = 3; m_left = 5; end
        else if (b[0]) begin e_ty = 3; if (b[7]) begin m_mode = 4; m_left = 4; end end
        else if (b[7]) e_ty = 4;
        else e_ty = 5;
      end else if (m_mode == 2) begin
        if (b == 8'h00) begin e_py = 1; if (m_left > 0) m_left--; end
        else if (b == 8'h80 && m_left == 0) begin e_py = 1; m_mode = 1; end
        else begin e_un = 1; m_mode = 0; m_zeros = 0; end
      end else if (m_mode == 3) begin
        e_py = 1; m_left--;
        if (m_left == 0) m_mode = 1;
      end else begin
        e_py = 1; m_left--;
        if (!b[7] || m_left == 0) m_mode = 1;
      end
    end
    @(negedge clk);
    compare(tag, m_mode != 0, e_un, e_hd, e_ty, e_py, c);
  endtask

  task automatic feed(input logic [7:0] b, input string tag);
    step(1'b1, b, 1'b1, 1'b0, tag);
  endtask

  task automatic relock(input string tag);
    for (int i = 0; i < 6; i++) feed(8'h00, tag);
    feed(8'h80, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    miscompares++;
    $display("FAIL watchdog: got hung run exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [7:0] lfsr;
    vectors = 0; miscompares = 0;
    m_mode = 0; m_zeros = 0; m_left = 0;
    rst_n = 1'b0; clr = 1'b0; ce = 1'b1; in_valid = 1'b0; in_data = 8'h00;
    repeat (3) @(negedge clk);
    compare("R1 reset", 0, 0, 0, 0, 0, 1);
    rst_n = 1'b1;
    step(1'b0, 8'h00, 1'b1, 1'b0, "R1 idle after reset");

    // R2: arbitrary bytes while hunting
    feed(8'h4b, "R2"); feed(8'h90, "R2"); feed(8'h08, "R2"); feed(8'h80, "R2");
    // R3: four zeros then 0x80 must not lock
    for (int i = 0; i < 4; i++) feed(8'h00, "R3 short run");
    feed(8'h80, "R3 short run close");
    // R3: long zero run then 0x80 locks
    for (int i = 0; i < 8; i++) feed(8'h00, "R3 long run");
    feed(8'h80, "R3 lock");

    // R5: instruction sync, payload holds header-like bytes
    feed(8'h08, "R5 header");
    feed(8'h4b, "R5 payload"); feed(8'h90, "R5 payload"); feed(8'h00, "R5 payload");
    feed(8'h08, "R5 payload"); feed(8'h80, "R5 payload");
    // R7: atom right after
    feed(8'h90, "R7 atom"); feed(8'h80, "R7 atom");

    // R6: branch running to the five-byte cap
    feed(8'hcb, "R6 header"); feed(8'h81, "R6 cont"); feed(8'h80, "R6 cont");
    feed(8'hff, "R6 cont"); feed(8'hff, "R6 last at cap");
    feed(8'h4b, "R6 single-byte branch"); feed(8'hc1, "R6 header");
    feed(8'h05, "R6 end by bit7 clear"); feed(8'h90, "R6 next header");

    // R9: other headers
    feed(8'h04, "R9 other"); feed(8'h02, "R9 other");

    // R11: ce low holds, valid low gives nothing
    step(1'b1, 8'h08, 1'b0, 1'b0, "R11 ce low");
    step(1'b1, 8'h00, 1'b0, 1'b0, "R11 ce low");
    step(1'b0, 8'h08, 1'b1, 1'b0, "R4 no valid");
    feed(8'h90, "R11 still header after hold");

    // R8: in-stream alignment packet, good then malformed
    feed(8'h00, "R8 header");
    for (int i = 0; i < 4; i++) feed(8'h00, "R8 zeros");
    feed(8'h80, "R8 close"); feed(8'h90, "R8 next header");
    feed(8'h00, "R8 header"); feed(8'h00, "R8 zero"); feed(8'h80, "R8 early close loses lock");
    feed(8'h90, "R8 unlocked after");

    // R10: flush with ce low
    relock("R10 relock");
    feed(8'h08, "R10 isync header");
    step(1'b1, 8'h90, 1'b0, 1'b1, "R10 flush");
    feed(8'h90, "R10 after flush");

    // pseudo-random traffic with periodic relock
    lfsr = 8'h5a;
    for (int k = 0; k < 400; k++) begin
      if (k % 60 == 0) relock("R3 relock");
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (lfsr[2:0] == 3'd0) step(1'b1, lfsr, 1'b0, 1'b0, "R11 random");
      else if (lfsr[2:0] == 3'd1) feed(8'h90, "R7 random");
      else if (lfsr[2:0] == 3'd2) feed(8'h08, "R5 random");
      else feed(lfsr, "R6 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule